// File: doc/BRIEF.md
# Register-List Block Transfer Sequencer

This block moves a group of low registers to or from memory in a single operation. A one-cycle start strobe supplies an 8-bit selection mask, the index of the register that holds the base address, a direction flag, and the current value of that base register. The sequencer then finds the set bits one after another, from the lowest index upward. For each set bit it issues one bus transaction at an address that starts at the base value and rises by one word for each register actually moved.

When the direction is store, the selected register is read through a combinational register-file read port and its value goes out as the write data. When the direction is load, the returned memory word is written into the selected register in the same cycle the bus accepts the transfer. After the last transfer the block writes the advanced address back into the base register through the same register-file write port, and it raises a one-cycle completion pulse.

The block sits between a decode stage and a shared load/store bus. Its bus request is held with a stable address until the memory side acknowledges, so any number of wait states is tolerated.

Top module: `blkxfer_seq`

## Requirements
- R1: Bit i of `list_i` selects low register i. Exactly one bus handshake (`mem_req_o` and `mem_ack_i` both high) happens per set bit, and none for a clear bit.
- R2: Registers are transferred in ascending index order. The index on `rf_rd_idx_o` strictly increases from one handshake to the next within an operation.
- R3: The first transfer of an operation presents the sampled base value on `mem_addr_o`. Its request is visible in the cycle after the start strobe.
- R4: The address rises by 4 after each completed handshake. Clear bits add nothing to it.
- R5: A store (`load_i`=0) drives `mem_we_o`=1 with the selected register's value on `mem_wdata_o`. A load (`load_i`=1) drives `mem_we_o`=0 and writes `mem_rdata_i` to the selected register (`rf_we_o`=1, `rf_wr_idx_o`=register index) in the handshake cycle.
- R6: After the transfers, the register-file write port writes base + 4 times the population count of the list into the base register. This write happens in the cycle `done_o` is high.
- R7: An empty list makes no bus request. It asserts `done_o` in the cycle after the start strobe and writes the base value back unchanged.
- R8: On a load whose list contains the base register, the final content of the base register is the updated address, not the loaded word.
- R9: `done_o` lasts exactly one cycle. `busy_o` is high from the cycle after the accepted start through the `done_o` cycle, and low after it. A start strobe that arrives while busy is ignored.
- R10: While a request waits for acknowledge, the request, address and register index stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe; accepted only while idle |
| list_i | input | NUM_REGS | Register selection mask |
| base_idx_i | input | IDX_W | Index of the base register |
| load_i | input | 1 | 1 = load from memory, 0 = store to memory |
| base_val_i | input | ADDR_W | Current value of the base register |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rf_rd_idx_o | output | IDX_W | Register-file read index (current register) |
| rf_rd_data_i | input | DATA_W | Register-file read data, combinational |
| rf_we_o | output | 1 | Register-file write enable |
| rf_wr_idx_o | output | IDX_W | Register-file write index |
| rf_wr_data_o | output | DATA_W | Register-file write data |
| mem_req_o | output | 1 | Bus request |
| mem_we_o | output | 1 | Bus write (store) qualifier |
| mem_addr_o | output | ADDR_W | Bus word address |
| mem_wdata_o | output | DATA_W | Bus write data |
| mem_ack_i | input | 1 | Bus acknowledge; completes the current transfer |
| mem_rdata_i | input | DATA_W | Bus read data, valid with acknowledge |

## Verification
The hardest case to reach is a load whose list includes the base register while the bus stalls. Two writes to the same register must land in the right order, and a stray start strobe must arrive mid-operation without disturbing the sequence. The bench reaches it by issuing a load with the base index inside a sparse list, and by running a full-list store under a throttled acknowledge pattern with a second start pulse injected while busy. The scoreboard then expects exactly one handshake per set bit and checks that the final register holds the advanced address.

// File: rtl/blkx_pkg.sv
package blkx_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_XFER  = 2'd1,
      ST_WBACK = 2'd2
   } blkx_state_e;

endpackage

// File: rtl/blkx_prio_enc.sv
module blkx_prio_enc #(
   parameter int N    = 8,
   parameter int IW   = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  mask_i,
   output logic [N-1:0]  onehot_o,
   output logic [IW-1:0] idx_o
);

   // Lowest set bit wins: one-hot isolation per bit position.
   for (genvar g = 0; g < N; g++) begin : g_oh
      if (g == 0) begin : g_lo
         assign onehot_o[g] = mask_i[0];
      end else begin : g_hi
         assign onehot_o[g] = mask_i[g] & ~(|mask_i[g-1:0]);
      end
   end

   always_comb begin
      idx_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (mask_i[i]) idx_o = IW'(i);
      end
   end

endmodule

// File: rtl/blkx_pend_reg.sv
module blkx_pend_reg #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_en_i,
   input  logic [N-1:0] load_val_i,
   input  logic         clr_en_i,
   input  logic [N-1:0] clr_onehot_i,
   output logic [N-1:0] pend_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_o <= '0;
      end else if (load_en_i) begin
         pend_o <= load_val_i;
      end else if (clr_en_i) begin
         pend_o <= pend_o & ~clr_onehot_i;
      end
   end

endmodule

// File: rtl/blkx_addr_ctr.sv
module blkx_addr_ctr #(
   parameter int AW     = 32,
   parameter int STRIDE = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_en_i,
   input  logic [AW-1:0] load_val_i,
   input  logic          step_en_i,
   output logic [AW-1:0] addr_o
);

   localparam logic [AW-1:0] STEP = AW'(STRIDE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_o <= '0;
      end else if (load_en_i) begin
         addr_o <= load_val_i;
      end else if (step_en_i) begin
         addr_o <= addr_o + STEP;
      end
   end

endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
   import blkx_pkg::*;
#(
   parameter int NUM_REGS = 8,
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 32,
   parameter int STRIDE   = DATA_W / 8,
   localparam int IDX_W   = $clog2(NUM_REGS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic [NUM_REGS-1:0] list_i,
   input  logic [IDX_W-1:0]    base_idx_i,
   input  logic                load_i,
   input  logic [ADDR_W-1:0]   base_val_i,
   output logic                busy_o,
   output logic                done_o,
   output logic [IDX_W-1:0]    rf_rd_idx_o,
   input  logic [DATA_W-1:0]   rf_rd_data_i,
   output logic                rf_we_o,
   output logic [IDX_W-1:0]    rf_wr_idx_o,
   output logic [DATA_W-1:0]   rf_wr_data_o,
   output logic                mem_req_o,
   output logic                mem_we_o,
   output logic [ADDR_W-1:0]   mem_addr_o,
   output logic [DATA_W-1:0]   mem_wdata_o,
   input  logic                mem_ack_i,
   input  logic [DATA_W-1:0]   mem_rdata_i
);

   // Elaboration-time parameter checks
   if (NUM_REGS < 2) begin : g_bad_regs
      $error("blkxfer_seq: NUM_REGS must be at least 2");
   end
   if (DATA_W % 8 != 0) begin : g_bad_data
      $error("blkxfer_seq: DATA_W must be a whole number of bytes");
   end
   if (ADDR_W > DATA_W) begin : g_bad_addr
      $error("blkxfer_seq: ADDR_W must fit in a register");
   end
   if (STRIDE < 1) begin : g_bad_stride
      $error("blkxfer_seq: STRIDE must be positive");
   end

   blkx_state_e         state_q, state_d;
   logic [NUM_REGS-1:0] pend;
   logic [NUM_REGS-1:0] cur_oh;
   logic [IDX_W-1:0]    cur_idx;
   logic [ADDR_W-1:0]   addr;
   logic [IDX_W-1:0]    base_idx_q;
   logic                load_q;
   logic                accept;
   logic                fire;
   logic                last;

   assign accept = start_i && (state_q == ST_IDLE);
   assign fire   = (state_q == ST_XFER) && mem_ack_i;
   assign last   = ((pend & ~cur_oh) == '0);

   blkx_pend_reg #(.N(NUM_REGS)) u_pend (
      .clk          (clk),
      .rst_n        (rst_n),
      .load_en_i    (accept),
      .load_val_i   (list_i),
      .clr_en_i     (fire),
      .clr_onehot_i (cur_oh),
      .pend_o       (pend)
   );

   blkx_prio_enc #(.N(NUM_REGS), .IW(IDX_W)) u_pick (
      .mask_i   (pend),
      .onehot_o (cur_oh),
      .idx_o    (cur_idx)
   );

   blkx_addr_ctr #(.AW(ADDR_W), .STRIDE(STRIDE)) u_addr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_en_i  (accept),
      .load_val_i (base_val_i),
      .step_en_i  (fire),
      .addr_o     (addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_idx_q <= '0;
         load_q     <= 1'b0;
      end else if (accept) begin
         base_idx_q <= base_idx_i;
         load_q     <= load_i;
      end
   end

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (accept) state_d = (|list_i) ? ST_XFER : ST_WBACK;
         ST_XFER:  if (fire && last) state_d = ST_WBACK;
         ST_WBACK: state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   // Bus side
   assign mem_req_o   = (state_q == ST_XFER);
   assign mem_we_o    = mem_req_o && !load_q;
   assign mem_addr_o  = addr;
   assign mem_wdata_o = rf_rd_data_i;
   assign rf_rd_idx_o = cur_idx;

   // Single register-file write port: loaded words, then base write-back
   always_comb begin
      if (state_q == ST_WBACK) begin
         rf_we_o      = 1'b1;
         rf_wr_idx_o  = base_idx_q;
         rf_wr_data_o = DATA_W'(addr);
      end else begin
         rf_we_o      = fire && load_q;
         rf_wr_idx_o  = cur_idx;
         rf_wr_data_o = mem_rdata_i;
      end
   end

   assign busy_o = (state_q != ST_IDLE);
   assign done_o = (state_q == ST_WBACK);

endmodule

// File: rtl/blkxfer_seq_chk.sv
module blkxfer_seq_chk #(
   parameter int NUM_REGS = 8,
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 32,
   parameter int STRIDE   = DATA_W / 8,
   localparam int IDX_W   = $clog2(NUM_REGS)
) (
   input logic                clk,
   input logic                rst_n,
   input logic                start_i,
   input logic [NUM_REGS-1:0] list_i,
   input logic [ADDR_W-1:0]   base_val_i,
   input logic                busy_o,
   input logic                done_o,
   input logic [IDX_W-1:0]    rf_rd_idx_o,
   input logic                rf_we_o,
   input logic                mem_req_o,
   input logic                mem_we_o,
   input logic [ADDR_W-1:0]   mem_addr_o,
   input logic                mem_ack_i
);

   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STRIDE);

   AST_ASCENDING_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && mem_ack_i) |=> (!mem_req_o || rf_rd_idx_o > $past(rf_rd_idx_o))); // R2

   AST_FIRST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o && list_i != '0) |=> (mem_req_o && mem_addr_o == $past(base_val_i))); // R3

   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && mem_ack_i) |=> (!mem_req_o || mem_addr_o == $past(mem_addr_o) + STEP)); // R4

   AST_LOAD_NO_BUS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_we_o && mem_req_o) |-> !mem_we_o); // R5

   AST_EMPTY_LIST: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o && list_i == '0) |=> (done_o && !mem_req_o)); // R7

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (!done_o && !busy_o)); // R9

   AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (busy_o && rf_we_o)); // R9

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(rf_rd_idx_o))); // R10

endmodule

bind blkxfer_seq blkxfer_seq_chk #(
   .NUM_REGS (NUM_REGS),
   .DATA_W   (DATA_W),
   .ADDR_W   (ADDR_W),
   .STRIDE   (STRIDE)
) u_chk (.*);

// File: tb/blkxfer_seq_test.sv
module blkxfer_seq_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [7:0]  list_i = '0;
   logic [2:0]  base_idx_i = '0;
   logic        load_i = 1'b0;
   logic [31:0] base_val_i = '0;
   logic        busy_o, done_o;
   logic [2:0]  rf_rd_idx_o;
   logic [31:0] rf_rd_data_i;
   logic        rf_we_o;
   logic [2:0]  rf_wr_idx_o;
   logic [31:0] rf_wr_data_o;
   logic        mem_req_o, mem_we_o;
   logic [31:0] mem_addr_o, mem_wdata_o;
   logic        mem_ack_i = 1'b0;
   logic [31:0] mem_rdata_i;

   always #2 clk = ~clk;

   blkxfer_seq uut (.*);

   // Environment: register file and memory
   logic [31:0] regs [0:7];
   logic [31:0] mem  [0:255];
   assign rf_rd_data_i = regs[rf_rd_idx_o];
   assign mem_rdata_i  = mem[mem_addr_o[9:2]];

   always @(posedge clk) begin
      if (rf_we_o) regs[rf_wr_idx_o] <= rf_wr_data_o;
      if (mem_req_o && mem_ack_i && mem_we_o) mem[mem_addr_o[9:2]] <= mem_wdata_o;
   end

   // Acknowledge pattern with wait states
   logic [7:0] lfsr = 8'h5A;
   bit         heavy = 1'b0;
   always @(posedge clk) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
   always @(posedge clk) #1 mem_ack_i = heavy ? (lfsr[2:0] == 3'd0) : (lfsr[1:0] != 2'd0);

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int checks = 0;
   int fails  = 0;
   int done_cnt = 0;
   int xfer_cnt = 0;

   typedef struct { logic we; logic [31:0] addr; logic [31:0] data; } bus_item_t;
   typedef struct { logic [2:0] idx; logic [31:0] data; } rf_item_t;
   bus_item_t bus_q[$];
   rf_item_t  rf_q[$];

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // Monitor: pops expected items as the design produces them
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_req_o && mem_ack_i) begin
            xfer_cnt++;
            if (bus_q.size() == 0) begin
               check(1'b0, "R1 unexpected bus transfer", mem_addr_o, 32'hFFFF_FFFF);
            end else begin
               bus_item_t b;
               b = bus_q.pop_front();
               check(mem_addr_o == b.addr, "R2/R3/R4 transfer address", mem_addr_o, b.addr);
               check(mem_we_o == b.we, "R5 bus direction", {31'd0, mem_we_o}, {31'd0, b.we});
               if (b.we) check(mem_wdata_o == b.data, "R5 store data", mem_wdata_o, b.data);
            end
         end
         if (rf_we_o) begin
            if (rf_q.size() == 0) begin
               check(1'b0, "R5/R6 unexpected register write", rf_wr_data_o, 32'hFFFF_FFFF);
            end else begin
               rf_item_t r;
               r = rf_q.pop_front();
               check(rf_wr_idx_o == r.idx, "R5/R6 register write index", {29'd0, rf_wr_idx_o}, {29'd0, r.idx});
               check(rf_wr_data_o == r.data, "R5/R6 register write data", rf_wr_data_o, r.data);
            end
         end
         if (done_o) done_cnt++;
      end
   end

   // Driver: computes expectations, pushes them, starts the operation
   task automatic run_op(input logic [7:0] lst, input logic [2:0] bidx, input bit ld,
                         input logic [31:0] base, input bit poke);
      logic [31:0] a;
      int          n;
      int          t0;
      int          dc0;
      a = base;
      n = 0;
      for (int i = 0; i < 8; i++) begin
         if (lst[i]) begin
            bus_item_t b;
            b.we = !ld; b.addr = a; b.data = regs[i];
            bus_q.push_back(b);
            if (ld) begin
               rf_item_t r;
               r.idx = 3'(i); r.data = mem[a[9:2]];
               rf_q.push_back(r);
            end
            a = a + 32'd4;
            n++;
         end
      end
      begin
         rf_item_t r;
         r.idx = bidx; r.data = base + 32'(4 * n);
         rf_q.push_back(r);
      end
      dc0 = done_cnt;
      @(negedge clk);
      start_i = 1'b1; list_i = lst; base_idx_i = bidx; load_i = ld; base_val_i = base;
      @(negedge clk);
      start_i = 1'b0; list_i = 8'h00; base_val_i = 32'hDEAD_0000;
      t0 = cyc;
      check(busy_o == 1'b1, "R9 busy after start", {31'd0, busy_o}, 32'd1);
      if (lst == 8'h00)
         check(done_o == 1'b1, "R7 empty list done next cycle", {31'd0, done_o}, 32'd1);
      if (poke) begin
         @(negedge clk);
         @(negedge clk);
         start_i = 1'b1; list_i = 8'hFF; load_i = 1'b1; base_val_i = 32'h0000_0300; base_idx_i = 3'd2;
         @(negedge clk);
         start_i = 1'b0; list_i = 8'h00;
      end
      while (!done_o && (cyc - t0) < 5000) @(negedge clk);
      check(done_o == 1'b1, "R9 done reached", {31'd0, done_o}, 32'd1);
      check(busy_o == 1'b1, "R9 busy in done cycle", {31'd0, busy_o}, 32'd1);
      @(negedge clk);
      check(!busy_o && !done_o, "R9 idle after one-cycle done", {30'd0, busy_o, done_o}, 32'd0);
      check(done_cnt == dc0 + 1, "R9 single done per operation", 32'(done_cnt - dc0), 32'd1);
      check(bus_q.size() == 0, "R1 all listed registers transferred", 32'(bus_q.size()), 32'd0);
      check(rf_q.size() == 0, "R6 base write-back performed", 32'(rf_q.size()), 32'd0);
      check(regs[bidx] == base + 32'(4 * n), "R6/R8 final base register", regs[bidx], base + 32'(4 * n));
   endtask

   initial begin
      for (int i = 0; i < 8; i++) regs[i] = 32'h1000_0000 + 32'(i) * 32'h0111_0111;
      for (int i = 0; i < 256; i++) mem[i] = 32'hA500_0000 ^ (32'(i) * 32'h0001_0203);
      fork
         begin
            repeat (3) @(negedge clk);
            check(!busy_o && !done_o && !mem_req_o && !rf_we_o, "R9 reset state",
                  {28'd0, busy_o, done_o, mem_req_o, rf_we_o}, 32'd0);
            rst_n = 1'b1;
            repeat (2) @(negedge clk);
            // R1 R4 R5: sparse store
            run_op(8'hA5, 3'd3, 1'b0, 32'h0000_0100, 1'b0);
            // R2 R5: contiguous load
            run_op(8'h3C, 3'd0, 1'b1, 32'h0000_0200, 1'b0);
            // R7: empty list
            begin
               int x0;
               x0 = xfer_cnt;
               run_op(8'h00, 3'd5, 1'b1, 32'h0000_0040, 1'b0);
               check(xfer_cnt == x0, "R7 no bus transfer", 32'(xfer_cnt - x0), 32'd0);
            end
            // R8: load with base register in list
            run_op(8'h12, 3'd4, 1'b1, 32'h0000_0300, 1'b0);
            // R9 R10: full store, heavy wait states, start while busy
            heavy = 1'b1;
            run_op(8'hFF, 3'd7, 1'b0, 32'h0000_0080, 1'b1);
            // R3: single high bit
            heavy = 1'b0;
            run_op(8'h80, 3'd1, 1'b0, 32'h0000_003C, 1'b0);
            // R5: read back the stored region
            heavy = 1'b1;
            run_op(8'h7F, 3'd7, 1'b1, 32'h0000_0080, 1'b0);
            heavy = 1'b0;
            run_op(8'h01, 3'd6, 1'b1, 32'h0000_0100, 1'b0);
            repeat (4) @(negedge clk);
         end
         begin
            wait (cyc > 100000);
            fails++;
            $display("FAIL watchdog: all requirements actual=hung expected=completion");
         end
      join_any
      disable fork;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule